// File: doc/BRIEF.md
# Add/Subtract Condition Flag Generator

This block performs one of four integer operations on two operands: plain addition, addition with an incoming carry, plain subtraction, and subtraction with an incoming carry. It produces the sum or difference at once, without a register. From the same operands it derives the four condition flags: negative, zero, carry and overflow. For subtraction, the carry flag means that no borrow took place.

The flags go into a single 4-bit register. On a clock edge where the flag write enable is high, that register takes either the freshly computed flags or a packed 4-bit flag word supplied from outside. A flag-restore path selects the packed word. When the enable is low the register keeps its value. Callers sequence the register one operation per cycle. They read the result combinationally and read the flags one cycle later.

Top module: `cond_flag_unit`

## Requirements
- R1: `result` is combinational. `op_sel` 0 gives op_a+op_b, 1 gives op_a+op_b+c_in, 2 gives op_a-op_b, and 3 gives op_a+~op_b+c_in, all modulo 2^WIDTH. `c_in` has no effect on `result` for codes 0 and 2.
- R2: For code 0, the computed carry is 1 exactly when `result` is unsigned-less-than `op_a`.
- R3: For code 1, the computed carry is 1 when `result` is unsigned-less-than `op_a`, or when `result` equals `op_a` and `c_in` is 1.
- R4: For code 2, the computed carry is 1 exactly when `op_a` is unsigned-greater-than-or-equal to `op_b`, meaning no borrow.
- R5: For code 3, the computed carry is 1 when `op_a` is unsigned-greater-than `op_b`, or when the two are equal and `c_in` is 1.
- R6: For codes 0 and 1, the computed overflow is the top bit of (result XOR op_a) AND NOT (op_a XOR op_b).
- R7: For codes 2 and 3, the computed overflow is the top bit of (result XOR op_a) AND (op_a XOR op_b).
- R8: The computed negative flag is the top bit of `result`. The computed zero flag is 1 exactly when every bit of `result` is 0.
- R9: `flags_q` holds negative in bit 3, zero in bit 2, carry in bit 1 and overflow in bit 0. On an enabled edge with `load_packed` high, `flags_q` takes `packed_flags` bit for bit in that same order. With `load_packed` low it takes the computed flags.
- R10: On an edge where `flags_we` is low, `flags_q` keeps its value, whatever the other inputs are doing.
- R11: While `rst` is high at a rising edge, `flags_q` becomes 0000, and this takes priority over any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| c_in | input | 1 | Incoming carry for codes 1 and 3 |
| op_sel | input | 2 | Operation code (0 add, 1 add with carry, 2 subtract, 3 subtract with carry) |
| flags_we | input | 1 | Flag register write enable |
| load_packed | input | 1 | Selects `packed_flags` as the flag register source |
| packed_flags | input | 4 | Packed flag word {N,Z,C,V} |
| result | output | WIDTH | Combinational sum or difference |
| flags_q | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The assertions require every input to be a known 0/1 value at each rising edge outside reset. They also assume that `op_sel` codes have fixed meanings: bit 1 selects subtraction and bit 0 selects use of `c_in`. The bench changes its inputs only on falling edges and holds every input defined from time zero. Because of this, each edge sees one stable, fully known operation. The carry and overflow references in the checker come from a widened adder and from sign comparisons, not from the comparison rules the design uses. The bench sweeps all operand pairs of a 4-bit instance under every code and carry-in.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_ADC = 2'd1,
    OP_SUB = 2'd2,
    OP_SBC = 2'd3
  } arith_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
  localparam int FLAG_W = 4;
endpackage

// File: rtl/cfu_sum.sv
module cfu_sum #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             c_in,
  input  cfu_pkg::arith_op_e op,
  output logic [WIDTH-1:0] result
);
  logic             is_sub;
  logic             use_cin;
  logic [WIDTH-1:0] b_eff;
  logic             ci;

  always_comb begin
    is_sub  = op[1];
    use_cin = op[0];
    b_eff   = is_sub ? ~op_b : op_b;
    ci      = use_cin ? c_in : is_sub;
    result  = op_a + b_eff + {{(WIDTH-1){1'b0}}, ci};
  end
endmodule

// File: rtl/cfu_carry.sv
module cfu_carry #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [WIDTH-1:0] result,
  input  logic             c_in,
  input  cfu_pkg::arith_op_e op,
  output logic             carry
);
  import cfu_pkg::*;

  always_comb begin
    unique case (op)
      OP_ADD:  carry = (result < op_a);
      OP_ADC:  carry = (result < op_a) || ((result == op_a) && c_in);
      OP_SUB:  carry = !(op_a < op_b);
      default: carry = (op_a > op_b) || ((op_a == op_b) && c_in);
    endcase
  end
endmodule

// File: rtl/cfu_ovf.sv
module cfu_ovf #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [WIDTH-1:0] result,
  input  logic             is_sub,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH-1:0] res_diff;
  logic [WIDTH-1:0] opr_diff;
  logic [WIDTH-1:0] mixed;

  always_comb begin
    res_diff = result ^ op_a;
    opr_diff = op_a ^ op_b;
    mixed    = is_sub ? (res_diff & opr_diff) : (res_diff & ~opr_diff);
    ovf      = mixed[MSB];
  end
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             c_in,
  input  logic [1:0]       op_sel,
  input  logic             flags_we,
  input  logic             load_packed,
  input  logic [3:0]       packed_flags,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       flags_q
);
  import cfu_pkg::*;

  arith_op_e         op;
  logic              c_calc;
  logic              v_calc;
  logic [FLAG_W-1:0] flags_calc;
  logic [FLAG_W-1:0] flags_next;

  assign op = arith_op_e'(op_sel);

  cfu_sum #(.WIDTH(WIDTH)) u_sum (
    .op_a   (op_a),
    .op_b   (op_b),
    .c_in   (c_in),
    .op     (op),
    .result (result)
  );

  cfu_carry #(.WIDTH(WIDTH)) u_carry (
    .op_a   (op_a),
    .op_b   (op_b),
    .result (result),
    .c_in   (c_in),
    .op     (op),
    .carry  (c_calc)
  );

  cfu_ovf #(.WIDTH(WIDTH)) u_ovf (
    .op_a   (op_a),
    .op_b   (op_b),
    .result (result),
    .is_sub (op_sel[1]),
    .ovf    (v_calc)
  );

  always_comb begin
    flags_calc         = '0;
    flags_calc[FLAG_N] = result[WIDTH-1];
    flags_calc[FLAG_Z] = (result == '0);
    flags_calc[FLAG_C] = c_calc;
    flags_calc[FLAG_V] = v_calc;
    flags_next         = load_packed ? packed_flags : flags_calc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (flags_we) begin
      flags_q <= flags_next;
    end
  end
endmodule

// File: rtl/cond_flag_unit_chk.sv
module cond_flag_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             c_in,
  input logic [1:0]       op_sel,
  input logic             flags_we,
  input logic             load_packed,
  input logic [3:0]       packed_flags,
  input logic [WIDTH-1:0] result,
  input logic [3:0]       flags_q
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   ext_sum;
  logic [WIDTH:0]   b_ext;
  logic             ci_ref;
  logic             carry_ref;
  logic             ovf_ref;
  logic             sa, sb, sr;
  logic             calc_we;

  always_comb begin
    b_ext     = op_sel[1] ? {1'b0, ~op_b} : {1'b0, op_b};
    ci_ref    = op_sel[0] ? c_in : op_sel[1];
    ext_sum   = {1'b0, op_a} + b_ext + {{WIDTH{1'b0}}, ci_ref};
    carry_ref = ext_sum[WIDTH];
    sa        = op_a[MSB];
    sb        = op_b[MSB] ^ op_sel[1];
    sr        = ext_sum[MSB];
    ovf_ref   = (sa == sb) && (sr != sa);
    calc_we   = flags_we && !load_packed;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> flags_q == 4'b0000); // R11
  AST_RESULT_SUM: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> result == ext_sum[WIDTH-1:0]); // R1
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flags_we |=> $stable(flags_q)); // R10
  AST_PACKED_LOAD: assert property (@(posedge clk) disable iff (rst)
    flags_we && load_packed |=> flags_q == $past(packed_flags)); // R9
  AST_CARRY_OUT: assert property (@(posedge clk) disable iff (rst)
    calc_we |=> flags_q[1] == $past(carry_ref)); // R2 R3 R4 R5
  AST_SIGNED_OVF: assert property (@(posedge clk) disable iff (rst)
    calc_we |=> flags_q[0] == $past(ovf_ref)); // R6 R7
  AST_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
    calc_we |=> flags_q[3] == $past(sr) && flags_q[2] == ($past(ext_sum[WIDTH-1:0]) == '0)); // R8
endmodule

bind cond_flag_unit cond_flag_unit_chk #(.WIDTH(WIDTH)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .op_a         (op_a),
  .op_b         (op_b),
  .c_in         (c_in),
  .op_sel       (op_sel),
  .flags_we     (flags_we),
  .load_packed  (load_packed),
  .packed_flags (packed_flags),
  .result       (result),
  .flags_q      (flags_q)
);

// File: tb/test_cond_flag_unit.sv
module test_cond_flag_unit;
  localparam int W    = 4;
  localparam int SPAN = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         c_in = 1'b0;
  logic [1:0]   op_sel = 2'd0;
  logic         flags_we = 1'b0;
  logic         load_packed = 1'b0;
  logic [3:0]   packed_flags = 4'd0;
  logic [W-1:0] result;
  logic [3:0]   flags_q;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cond_flag_unit #(.WIDTH(W)) i_cond_flag_unit (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .c_in(c_in),
    .op_sel(op_sel), .flags_we(flags_we), .load_packed(load_packed),
    .packed_flags(packed_flags), .result(result), .flags_q(flags_q)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int to_signed(int v);
    return (v >= SPAN / 2) ? v - SPAN : v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R11 reset flags", int'(flags_q), 0);
    @(negedge clk) rst = 1'b0;

    // R1..R8 exhaustive sweep
    for (int op = 0; op < 4; op++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int a = 0; a < SPAN; a++) begin
          for (int b = 0; b < SPAN; b++) begin
            int full, er, ec, sv, ev, en, ez, cuse;
            @(negedge clk);
            op_a = W'(a); op_b = W'(b); c_in = ci[0]; op_sel = op[1:0];
            flags_we = 1'b1; load_packed = 1'b0;
            cuse = (op == 1 || op == 3) ? ci : (op == 2 ? 1 : 0);
            if (op >= 2) begin
              full = a + ((~b) & (SPAN - 1)) + cuse;
              sv   = to_signed(a) - to_signed(b) - (1 - cuse);
            end else begin
              full = a + b + cuse;
              sv   = to_signed(a) + to_signed(b) + cuse;
            end
            er = full % SPAN;
            ec = (full / SPAN) % 2;
            ev = (sv > SPAN / 2 - 1 || sv < -(SPAN / 2)) ? 1 : 0;
            en = (er >= SPAN / 2) ? 1 : 0;
            ez = (er == 0) ? 1 : 0;
            #1 check("R1 result", int'(result), er);
            @(posedge clk);
            #1;
            case (op)
              0: check("R2 add carry", int'(flags_q[1]), ec);
              1: check("R3 adc carry", int'(flags_q[1]), ec);
              2: check("R4 sub carry", int'(flags_q[1]), ec);
              default: check("R5 sbc carry", int'(flags_q[1]), ec);
            endcase
            if (op < 2) check("R6 add ovf", int'(flags_q[0]), ev);
            else        check("R7 sub ovf", int'(flags_q[0]), ev);
            check("R8 neg/zero", int'(flags_q[3:2]), en * 2 + ez);
          end
        end
      end
    end

    // R9 packed load, every value
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      op_a = W'(v); op_b = '0; op_sel = 2'd0;
      flags_we = 1'b1; load_packed = 1'b1; packed_flags = v[3:0];
      @(posedge clk);
      #1 check("R9 packed load", int'(flags_q), v);
    end

    // R10 hold while write enable is low
    @(negedge clk);
    flags_we = 1'b1; load_packed = 1'b1; packed_flags = 4'b1010;
    @(negedge clk);
    flags_we = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      op_a = W'(k); op_b = W'(15 - k); op_sel = k[1:0]; c_in = k[0];
      load_packed = k[0]; packed_flags = 4'b0101;
      @(posedge clk);
      #1 check("R10 hold", int'(flags_q), 4'b1010);
    end

    // R11 reset wins over an enabled write
    @(negedge clk);
    rst = 1'b1; flags_we = 1'b1; load_packed = 1'b1; packed_flags = 4'b1111;
    @(posedge clk);
    #1 check("R11 reset priority", int'(flags_q), 0);
    @(negedge clk) rst = 1'b0; flags_we = 1'b0;
    @(posedge clk);
    finish_run();
  end
endmodule